// File: doc/BRIEF.md
# Redundant Store Output Comparator

This block sits at the edge of a replicated execution domain, where two redundant threads run the same program. Each thread hands over its committed memory operations in program order. These operations are stores, uncached loads and cached loads. The block pairs the n-th kept record of the leading thread with the n-th kept record of the trailing thread. A store leaves the domain towards the data cache only after both copies have arrived and agree.

The two threads commit the same operation in different cycles, so the block does not compare them in lockstep. Each thread feeds its own in-order buffer. A pair is compared only once the oldest entries of both buffers are present. A store must match in kind, address and data. An uncached load must match in kind and address only. Cached loads are accepted and dropped at the input, because they carry nothing that leaves the domain.

A disagreement raises a sticky fault flag. The failing operation is withheld, and nothing more is released until reset.

Top module: `store_out_cmp`

## Requirements
- R1: A store (kind 2'b01) is released only when both copies agree in address and data. A difference in either one raises the fault and releases nothing.
- R2: The two copies of an operation may arrive in different cycles, in either order. The release appears on the first clock edge after the later copy has been accepted, with rel_valid high for that one cycle.
- R3: For an uncached load (kind 2'b10), only the address is compared. A difference in data is ignored and the load is released with kind 2'b10 and the leading thread's address and data. A difference in address raises the fault.
- R4: A record of kind 2'b00 (cached load) or 2'b11 (unused) is accepted and discarded. It never takes part in pairing and never produces a release or a fault.
- R5: Kept records are paired strictly by position. The n-th kept record of one thread is compared with the n-th kept record of the other, and releases leave in that order.
- R6: When paired records differ in kind, the fault is raised and nothing is released.
- R7: The fault flag stays high until reset. Once it is set, no further release occurs, even for later pairs that match.
- R8: Each thread buffers up to DEPTH kept records, 8 by default. When a thread's buffer is full, its ready output is low and a record offered meanwhile is not taken. Each release frees one entry in both buffers.
- R9: After reset, fault and rel_valid are low and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lead_valid | input | 1 | Leading thread offers a committed record |
| lead_ready | output | 1 | Leading thread's buffer can take a record |
| lead_kind | input | 2 | Record kind: 00 cached load, 01 store, 10 uncached load, 11 unused |
| lead_addr | input | ADDR_W | Leading record address |
| lead_data | input | DATA_W | Leading record data |
| trail_valid | input | 1 | Trailing thread offers a committed record |
| trail_ready | output | 1 | Trailing thread's buffer can take a record |
| trail_kind | input | 2 | Record kind, same encoding as lead_kind |
| trail_addr | input | ADDR_W | Trailing record address |
| trail_data | input | DATA_W | Trailing record data |
| rel_valid | output | 1 | One-cycle pulse: a validated operation is released |
| rel_kind | output | 2 | Kind of the released operation |
| rel_addr | output | ADDR_W | Address of the released operation |
| rel_data | output | DATA_W | Data of the released operation |
| fault | output | 1 | Sticky mismatch flag |

## Verification
The hardest state to reach from the ports is a full buffer on one thread while the other thread lags behind. In that state, a record offered to the full side must be visibly refused. The bench commits DEPTH stores on the leading side only and reads its ready output. It then offers one more record with a distinct address. Next it replays the stores on the trailing side, checking each release in order. Finally it sends the distinct address on the trailing side and confirms that no release follows, which shows that the refused record never entered the buffer. Skewed arrival is reached the same way: the leading side runs several records ahead, and a cached load is slipped into the trailing stream.

// File: rtl/store_cmp_pkg.sv
// Shared kind encoding for the redundant store output comparator.
// Assumes a 2-bit kind field on both commit streams.
package store_cmp_pkg;
    typedef enum logic [1:0] {
        KIND_CACHED   = 2'b00,
        KIND_STORE    = 2'b01,
        KIND_UNCACHED = 2'b10,
        KIND_UNUSED   = 2'b11
    } kind_e;

    // Returns 1 for kinds that must be paired and compared.
    function automatic logic kind_is_checked(input logic [1:0] k);
        return (k == KIND_STORE) || (k == KIND_UNCACHED);
    endfunction
endpackage

// File: rtl/commit_fifo.sv
// In-order buffer for one thread's committed records.
// Takes a record when valid, ready and keep are all high; drops it when keep is low.
// Assumes pop is raised only while head_valid is high.
module commit_fifo #(
    parameter int DEPTH = 8,
    parameter int REC_W = 66
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_keep,
    input  logic [REC_W-1:0] in_rec,
    output logic             in_ready,
    input  logic             pop,
    output logic             head_valid,
    output logic [REC_W-1:0] head_rec
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [REC_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push;

    assign in_ready   = (count != CNT_W'(DEPTH));
    assign push       = in_valid && in_ready && in_keep;
    assign head_valid = (count != '0);
    assign head_rec   = mem[rd_ptr];

    // Store the incoming record at the write slot.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= in_rec;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R5
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
endmodule

// File: rtl/pair_checker.sv
// Compares the head records of the two threads and issues releases.
// Assumes each head stays stable until popped. Once a fault is seen, it holds
// both heads and all releases frozen until reset.
module pair_checker
    import store_cmp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_valid,
    input  logic [1:0]        l_kind,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_data,
    input  logic              t_valid,
    input  logic [1:0]        t_kind,
    input  logic [ADDR_W-1:0] t_addr,
    input  logic [DATA_W-1:0] t_data,
    output logic              pop,
    output logic              rel_valid,
    output logic [1:0]        rel_kind,
    output logic [ADDR_W-1:0] rel_addr,
    output logic [DATA_W-1:0] rel_data,
    output logic              fault
);
    logic both;
    logic agree;

    assign both = l_valid && t_valid;

    // Decide whether the paired heads agree; data counts only for stores.
    always_comb begin
        agree = (l_kind == t_kind) && (l_addr == t_addr);
        if (l_kind == KIND_STORE && l_data != t_data) agree = 1'b0;
    end

    assign pop = both && agree && !fault;

    // Register the release and latch the sticky fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_valid <= 1'b0;
            rel_kind  <= '0;
            rel_addr  <= '0;
            rel_data  <= '0;
            fault     <= 1'b0;
        end else begin
            rel_valid <= pop;
            if (pop) begin
                rel_kind <= l_kind;
                rel_addr <= l_addr;
                rel_data <= l_data;
            end
            if (both && !agree) fault <= 1'b1;
        end
    end

    // R7
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    // R7
    no_release_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !rel_valid);

    // R4
    release_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (rel_kind == KIND_STORE || rel_kind == KIND_UNCACHED));

    // R2
    release_paired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> $past(both));
endmodule

// File: rtl/store_out_cmp.sv
// Top of the redundant store output comparator.
// Buffers each thread's checked records in order, pairs them by position, and
// releases validated stores and uncached loads. Assumes that each thread commits
// in program order.
module store_out_cmp
    import store_cmp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lead_valid,
    output logic              lead_ready,
    input  logic [1:0]        lead_kind,
    input  logic [ADDR_W-1:0] lead_addr,
    input  logic [DATA_W-1:0] lead_data,
    input  logic              trail_valid,
    output logic              trail_ready,
    input  logic [1:0]        trail_kind,
    input  logic [ADDR_W-1:0] trail_addr,
    input  logic [DATA_W-1:0] trail_data,
    output logic              rel_valid,
    output logic [1:0]        rel_kind,
    output logic [ADDR_W-1:0] rel_addr,
    output logic [DATA_W-1:0] rel_data,
    output logic              fault
);
    localparam int REC_W = 2 + ADDR_W + DATA_W;
    localparam int NTHR  = 2;

    logic             in_v   [NTHR];
    logic             in_rdy [NTHR];
    logic [REC_W-1:0] in_r   [NTHR];
    logic             hd_v   [NTHR];
    logic [REC_W-1:0] hd_r   [NTHR];
    logic             pop;

    assign in_v[0] = lead_valid;
    assign in_v[1] = trail_valid;
    assign in_r[0] = {lead_kind, lead_addr, lead_data};
    assign in_r[1] = {trail_kind, trail_addr, trail_data};
    assign lead_ready  = in_rdy[0];
    assign trail_ready = in_rdy[1];

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        commit_fifo #(.DEPTH(DEPTH), .REC_W(REC_W)) i_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (in_v[g]),
            .in_keep    (kind_is_checked(in_r[g][REC_W-1 -: 2])),
            .in_rec     (in_r[g]),
            .in_ready   (in_rdy[g]),
            .pop        (pop),
            .head_valid (hd_v[g]),
            .head_rec   (hd_r[g])
        );
    end

    pair_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .l_valid   (hd_v[0]),
        .l_kind    (hd_r[0][REC_W-1 -: 2]),
        .l_addr    (hd_r[0][DATA_W +: ADDR_W]),
        .l_data    (hd_r[0][DATA_W-1:0]),
        .t_valid   (hd_v[1]),
        .t_kind    (hd_r[1][REC_W-1 -: 2]),
        .t_addr    (hd_r[1][DATA_W +: ADDR_W]),
        .t_data    (hd_r[1][DATA_W-1:0]),
        .pop       (pop),
        .rel_valid (rel_valid),
        .rel_kind  (rel_kind),
        .rel_addr  (rel_addr),
        .rel_data  (rel_data),
        .fault     (fault)
    );
endmodule

// File: tb/test_store_out_cmp.sv
module test_store_out_cmp;
    localparam int DEPTH = 8;

    typedef struct packed {
        logic [1:0]  lk;
        logic [31:0] la;
        logic [31:0] ld;
        logic [1:0]  tk;
        logic [31:0] ta;
        logic [31:0] td;
        logic        er;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 32'h0000_1000, 32'hDEAD_BEEF, 2'b01, 32'h0000_1000, 32'hDEAD_BEEF, 1'b1},
        '{2'b10, 32'h0000_2000, 32'h0000_0001, 2'b10, 32'h0000_2000, 32'h0000_0002, 1'b1},
        '{2'b00, 32'h0000_3000, 32'h0000_0005, 2'b00, 32'h0000_4000, 32'h0000_0006, 1'b0},
        '{2'b01, 32'hFFFF_FFFC, 32'h0000_0000, 2'b01, 32'hFFFF_FFFC, 32'h0000_0000, 1'b1},
        '{2'b11, 32'h0000_0010, 32'h0000_0011, 2'b11, 32'h0000_0020, 32'h0000_0022, 1'b0},
        '{2'b10, 32'h0000_0000, 32'hAAAA_5555, 2'b10, 32'h0000_0000, 32'hAAAA_5555, 1'b1}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        lead_valid = 0, trail_valid = 0;
    logic [1:0]  lead_kind = 0, trail_kind = 0;
    logic [31:0] lead_addr = 0, lead_data = 0, trail_addr = 0, trail_data = 0;
    logic        lead_ready, trail_ready, rel_valid, fault;
    logic [1:0]  rel_kind;
    logic [31:0] rel_addr, rel_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    store_out_cmp #(.ADDR_W(32), .DATA_W(32), .DEPTH(DEPTH)) i_store_out_cmp (
        .clk(clk), .rst_n(rst_n),
        .lead_valid(lead_valid), .lead_ready(lead_ready), .lead_kind(lead_kind),
        .lead_addr(lead_addr), .lead_data(lead_data),
        .trail_valid(trail_valid), .trail_ready(trail_ready), .trail_kind(trail_kind),
        .trail_addr(trail_addr), .trail_data(trail_data),
        .rel_valid(rel_valid), .rel_kind(rel_kind), .rel_addr(rel_addr),
        .rel_data(rel_data), .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic push_lead(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        lead_valid = 1; lead_kind = k; lead_addr = a; lead_data = d;
        @(negedge clk);
        lead_valid = 0;
    endtask

    task automatic push_trail(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        trail_valid = 1; trail_kind = k; trail_addr = a; trail_data = d;
        @(negedge clk);
        trail_valid = 0;
    endtask

    task automatic push_both(input logic [1:0] lk, input logic [31:0] la, input logic [31:0] ld,
                             input logic [1:0] tk, input logic [31:0] ta, input logic [31:0] td);
        @(negedge clk);
        lead_valid = 1; lead_kind = lk; lead_addr = la; lead_data = ld;
        trail_valid = 1; trail_kind = tk; trail_addr = ta; trail_data = td;
        @(negedge clk);
        lead_valid = 0; trail_valid = 0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R9 reset state
        chk(fault == 0, "R9 fault", fault, 0);
        chk(rel_valid == 0, "R9 rel_valid", rel_valid, 0);
        chk(lead_ready && trail_ready, "R9 ready", {lead_ready, trail_ready}, 2'b11);

        // Table walk: R1 R3 R4 matching pairs and discarded kinds
        for (int i = 0; i < NV; i++) begin
            push_both(VECS[i].lk, VECS[i].la, VECS[i].ld, VECS[i].tk, VECS[i].ta, VECS[i].td);
            @(negedge clk);
            chk(rel_valid == VECS[i].er, "R1/R3/R4 rel_valid", rel_valid, VECS[i].er);
            if (VECS[i].er) begin
                chk(rel_addr == VECS[i].la, "R1 rel_addr", rel_addr, VECS[i].la);
                chk(rel_data == VECS[i].ld, "R3 rel_data", rel_data, VECS[i].ld);
                chk(rel_kind == VECS[i].lk, "R3 rel_kind", rel_kind, VECS[i].lk);
            end
            chk(fault == 0, "R4 no fault", fault, 0);
        end

        // R2 R5: leading thread runs ahead, cached load slipped into the trailing stream
        do_reset();
        for (int i = 0; i < 3; i++) push_lead(2'b01, 32'h100 + i, 32'h900 + i);
        chk(rel_valid == 0, "R2 no release while trail absent", rel_valid, 0);
        for (int i = 0; i < 3; i++) begin
            if (i == 1) push_trail(2'b00, 32'h5555, 32'h6666);
            push_trail(2'b01, 32'h100 + i, 32'h900 + i);
            @(negedge clk);
            chk(rel_valid == 1, "R2 release after late copy", rel_valid, 1);
            chk(rel_addr == 32'h100 + i, "R5 release order", rel_addr, 32'h100 + i);
            @(negedge clk);
            chk(rel_valid == 0, "R2 single-cycle pulse", rel_valid, 0);
        end
        chk(fault == 0, "R4 cached load ignored in pairing", fault, 0);

        // R8: fill the leading buffer, offer one more, then drain through the trail side
        do_reset();
        for (int i = 0; i < DEPTH; i++) push_lead(2'b01, 32'h200 + i, 32'h300 + i);
        chk(lead_ready == 0, "R8 full lead not ready", lead_ready, 0);
        chk(trail_ready == 1, "R8 trail still ready", trail_ready, 1);
        push_lead(2'b01, 32'h7777, 32'h7777);
        for (int i = 0; i < DEPTH; i++) begin
            push_trail(2'b01, 32'h200 + i, 32'h300 + i);
            @(negedge clk);
            chk(rel_valid && rel_addr == 32'h200 + i, "R8 drain release", rel_addr, 32'h200 + i);
        end
        chk(lead_ready == 1, "R8 lead ready after drain", lead_ready, 1);
        push_trail(2'b01, 32'h7777, 32'h7777);
        @(negedge clk);
        chk(rel_valid == 0, "R8 refused record not buffered", rel_valid, 0);

        // R1 R7: data mismatch on a store, then sticky behaviour
        do_reset();
        push_both(2'b01, 32'h40, 32'h1, 2'b01, 32'h40, 32'h2);
        @(negedge clk);
        chk(rel_valid == 0, "R1 data mismatch withheld", rel_valid, 0);
        chk(fault == 1, "R1 data mismatch fault", fault, 1);
        push_both(2'b01, 32'h44, 32'h3, 2'b01, 32'h44, 32'h3);
        @(negedge clk);
        chk(rel_valid == 0, "R7 no release after fault", rel_valid, 0);
        repeat (3) @(negedge clk);
        chk(fault == 1, "R7 fault sticky", fault, 1);
        do_reset();
        chk(fault == 0, "R9 reset clears fault", fault, 0);

        // R1: store address mismatch
        push_both(2'b01, 32'h50, 32'h9, 2'b01, 32'h54, 32'h9);
        @(negedge clk);
        chk(fault == 1 && rel_valid == 0, "R1 address mismatch", {fault, rel_valid}, 2'b10);

        // R3: uncached load address mismatch
        do_reset();
        push_both(2'b10, 32'h60, 32'h0, 2'b10, 32'h64, 32'h0);
        @(negedge clk);
        chk(fault == 1 && rel_valid == 0, "R3 uncached address mismatch", {fault, rel_valid}, 2'b10);

        // R6: kind mismatch
        do_reset();
        push_both(2'b01, 32'h70, 32'h8, 2'b10, 32'h70, 32'h8);
        @(negedge clk);
        chk(fault == 1 && rel_valid == 0, "R6 kind mismatch", {fault, rel_valid}, 2'b10);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule